// File: doc/BRIEF.md
# Set/Clear/Toggle Control Register Bank

This block is a small bank of 32-bit control registers for a clock and analog control area. Each implemented register occupies a group of four consecutive words: the register itself, then a word that sets bits, a word that clears bits and a word that inverts bits. Software can therefore change single bits without a read-modify-write sequence. Every register has a fixed mask of bits that no write can change, whichever of the four words is used.

Registers take their reset values from a parameter vector. Registers flagged as oscillator-loop controls also carry a lock flag that reads as 1 from reset on and that no write can remove, because the analog loop itself is not modelled.

Access is through a single word-addressed request port with a valid/ready handshake. Every accepted request gets exactly one response one cycle later, carrying read data and an error flag.

Top module: `clkctl_regbank`

## Requirements
- R1: The byte address selects register group `addr >> 4`. Address bits [3:2] choose the access kind: 0 base word, 1 set word, 2 clear word, 3 toggle word.
- R2: A write to a base word gives `(old & mask) | (wdata & ~mask)`.
- R3: A write to a set word ORs `wdata & ~mask` into its register.
- R4: A write to a clear word clears the bits in `wdata & ~mask` in its register.
- R5: A write to a toggle word XORs `wdata & ~mask` into its register.
- R6: A read of any of the four words of a group returns the register's current value. Reads never change state.
- R7: Reset loads each register's parameter value. Masked bits never change after reset. A register whose mask is all ones ignores every write.
- R8: In lock-flagged registers, bit 31 (the lock flag) is 1 from reset on and stays 1 under every write kind.
- R9: An access with size code other than 2 (0 byte, 1 half, 2 word, 3 reserved), or with address bits [1:0] not zero, gets an error response with zero read data and changes no register.
- R10: An address whose word index is at or beyond 4 x NUM_REGS gets an error response with zero read data and changes no register.
- R11: `req_ready` is high from the first cycle after reset. A request is accepted when `req_valid` and `req_ready` are both high. `resp_valid` is high exactly in the cycle after each acceptance and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response present, one cycle after acceptance |
| resp_err | output | 1 | Access was rejected |
| resp_rdata | output | 32 | Read data; zero for writes and errors |

## Verification
On every cycle the assertions check the response timing, the error response with zero data, that rejected accesses and reads leave the whole register image unchanged, that masked bits never move, and that lock flags stay high. Only the bench scenarios can show the arithmetic of each write kind (replace, OR, clear, XOR under the mask), the reset values, and that alias words read back their base register. These depend on data values, which the bench computes itself.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int WORD_W = 32;

    // Access kind picked by address bits [3:2]
    typedef enum logic [1:0] {
        KIND_BASE = 2'd0,
        KIND_SET  = 2'd1,
        KIND_CLR  = 2'd2,
        KIND_TOG  = 2'd3
    } access_kind_e;

    // Size code of a full word access
    localparam logic [1:0] SIZE_WORD = 2'd2;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 8,
    parameter int GRP_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [GRP_W-1:0]  grp,
    output access_kind_e      kind,
    output logic              bad
);

    localparam int IDX_W     = ADDR_W - 2;
    localparam int NUM_WORDS = NUM_REGS * 4;

    logic [IDX_W-1:0] word_idx;
    logic             size_bad;
    logic             align_bad;
    logic             range_bad;

    always_comb begin
        word_idx  = addr[ADDR_W-1:2];
        grp       = GRP_W'(word_idx >> 2);
        kind      = access_kind_e'(word_idx[1:0]);
        size_bad  = (size != SIZE_WORD);
        align_bad = (addr[1:0] != 2'b00);
        range_bad = (32'(word_idx) >= NUM_WORDS);
        bad       = size_bad || align_bad || range_bad;
    end

endmodule

// File: rtl/regbank_update.sv
module regbank_update
    import regbank_pkg::*;
#(
    parameter logic [WORD_W-1:0] PROTECT = '0
) (
    input  logic [WORD_W-1:0] cur_val,
    input  logic              wr_en,
    input  access_kind_e      kind,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] nxt_val
);

    logic [WORD_W-1:0] eff;

    always_comb begin
        eff     = wdata & ~PROTECT;
        nxt_val = cur_val;
        if (wr_en) begin
            unique case (kind)
                KIND_BASE: nxt_val = (cur_val & PROTECT) | eff;
                KIND_SET:  nxt_val = cur_val | eff;
                KIND_CLR:  nxt_val = cur_val & ~eff;
                KIND_TOG:  nxt_val = cur_val ^ eff;
                default:   nxt_val = cur_val;
            endcase
        end
    end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 8,
    parameter int LOCK_POS = 31,
    parameter logic [NUM_REGS-1:0][WORD_W-1:0] RST_VALS = {
        32'h0000_3001, 32'hA5A5_0000, 32'h0000_0000, 32'h0000_1063
    },
    parameter logic [NUM_REGS-1:0][WORD_W-1:0] MASKS = {
        32'hFF00_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFF6_0F80
    },
    parameter logic [NUM_REGS-1:0] LOCK_EN = 4'b1001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [WORD_W-1:0] resp_rdata
);

    localparam int GRP_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [WORD_W-1:0] LOCK_ONE = WORD_W'(1) << LOCK_POS;

    typedef logic [NUM_REGS-1:0][WORD_W-1:0] image_t;

    function automatic image_t reset_image();
        image_t img;
        for (int i = 0; i < NUM_REGS; i++) begin
            img[i] = RST_VALS[i] | (LOCK_EN[i] ? LOCK_ONE : '0);
        end
        return img;
    endfunction

    localparam image_t RESET_IMAGE = reset_image();

    typedef struct packed {
        image_t            regs;
        logic              ready;
        logic              rvalid;
        logic              rerr;
        logic [WORD_W-1:0] rdata;
    } state_t;

    state_t state_d, state_q;

    logic              accept;
    logic [GRP_W-1:0]  grp;
    access_kind_e      kind;
    logic              bad;
    image_t            regs_q;
    image_t            upd_val;
    logic [NUM_REGS-1:0] wr_hit;

    assign regs_q = state_q.regs;
    assign accept = req_valid && state_q.ready;

    regbank_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .GRP_W    (GRP_W)
    ) u_decode (
        .addr (req_addr),
        .size (req_size),
        .grp  (grp),
        .kind (kind),
        .bad  (bad)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Lock flag joins the protected bits so no write kind can drop it
        localparam logic [WORD_W-1:0] PROTECT =
            MASKS[i] | (LOCK_EN[i] ? LOCK_ONE : '0);

        assign wr_hit[i] = accept && req_write && !bad && (grp == GRP_W'(i));

        regbank_update #(
            .PROTECT (PROTECT)
        ) u_update (
            .cur_val (regs_q[i]),
            .wr_en   (wr_hit[i]),
            .kind    (kind),
            .wdata   (req_wdata),
            .nxt_val (upd_val[i])
        );
    end

    always_comb begin
        state_d        = state_q;
        state_d.ready  = 1'b1;
        state_d.regs   = upd_val;
        state_d.rvalid = accept;
        state_d.rerr   = accept && bad;
        state_d.rdata  = '0;
        if (accept && !req_write && !bad) begin
            state_d.rdata = regs_q[grp];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.regs   <= RESET_IMAGE;
            state_q.ready  <= 1'b0;
            state_q.rvalid <= 1'b0;
            state_q.rerr   <= 1'b0;
            state_q.rdata  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready  = state_q.ready;
    assign resp_valid = state_q.rvalid;
    assign resp_err   = state_q.rerr;
    assign resp_rdata = state_q.rdata;

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 8,
    parameter int LOCK_POS = 31,
    parameter logic [NUM_REGS-1:0][WORD_W-1:0] MASKS = '0,
    parameter logic [NUM_REGS-1:0] LOCK_EN = '0
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            req_valid,
    input logic                            req_ready,
    input logic                            req_write,
    input logic [ADDR_W-1:0]               req_addr,
    input logic [1:0]                      req_size,
    input logic                            resp_valid,
    input logic                            resp_err,
    input logic [WORD_W-1:0]               resp_rdata,
    input logic [NUM_REGS-1:0][WORD_W-1:0] regs
);

    logic accept;
    logic rejected;

    assign accept   = req_valid && req_ready;
    assign rejected = (req_size != 2'd2) || (req_addr[1:0] != 2'b00) ||
                      (32'(req_addr[ADDR_W-1:2]) >= NUM_REGS * 4);

    // R11
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> resp_valid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !resp_valid);

    // R11
    ready_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);

    // R9
    bad_err_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rejected) |=> (resp_err && resp_rdata == '0));

    // R10
    bad_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rejected) |=> $stable(regs));

    // R6
    read_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write) |=> $stable(regs));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg_chk
        // R7
        protected_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(regs[i] & MASKS[i]));

        if (LOCK_EN[i]) begin : g_lock
            // R8
            lock_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
                regs[i][LOCK_POS]);
        end
    end

endmodule

bind clkctl_regbank regbank_chk #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .LOCK_POS (LOCK_POS),
    .MASKS    (MASKS),
    .LOCK_EN  (LOCK_EN)
) u_regbank_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata),
    .regs       (regs_q)
);

// File: tb/test_clkctl_regbank.sv
module test_clkctl_regbank;

    localparam time CLK_PERIOD = 10ns;
    localparam int  ADDR_W     = 8;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic        resp_err;
    logic [31:0] resp_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clkctl_regbank i_clkctl_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .resp_rdata (resp_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One access; the response is sampled at the negedge after the accepting edge
    task automatic bus(input logic wr, input logic [7:0] addr, input logic [1:0] size,
                       input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = size;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 resp_valid after accept", 32'(resp_valid), 32'd1);
        rd = resp_rdata;
        er = resp_err;
    endtask

    task automatic wr_ok(input string req, input logic [7:0] addr, input logic [31:0] wd);
        logic [31:0] rd;
        logic er;
        bus(1'b1, addr, 2'd2, wd, rd, er);
        check({req, " write no error"}, 32'(er), 32'd0);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] addr, input logic [31:0] exp);
        logic [31:0] rd;
        logic er;
        bus(1'b0, addr, 2'd2, '0, rd, er);
        check({req, " read no error"}, 32'(er), 32'd0);
        check({req, " read data"}, rd, exp);
    endtask

    task automatic t_reset();
        // R7 R8 R1: base words of each group
        rd_chk("R7 R8 reg0 reset", 8'h00, 32'h8000_1063);
        rd_chk("R7 reg1 reset", 8'h10, 32'h0000_0000);
        rd_chk("R7 reg2 reset", 8'h20, 32'hA5A5_0000);
        rd_chk("R7 R8 reg3 reset", 8'h30, 32'h8000_3001);
    endtask

    task automatic t_plain();
        wr_ok("R2", 8'h10, 32'hDEAD_BEEF);
        rd_chk("R2 reg1 full write", 8'h10, 32'hDEAD_BEEF);
        wr_ok("R2", 8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 reg0 masked write ones", 8'h00, 32'h8009_F07F);
        wr_ok("R2", 8'h00, 32'h0000_0000);
        rd_chk("R2 R8 reg0 masked write zeros", 8'h00, 32'h8000_0000);
    endtask

    task automatic t_readonly();
        wr_ok("R7", 8'h20, 32'hFFFF_FFFF);
        rd_chk("R7 read-only reg ignores ones", 8'h20, 32'hA5A5_0000);
        wr_ok("R7", 8'h24, 32'hFFFF_FFFF);
        wr_ok("R7", 8'h28, 32'hFFFF_FFFF);
        rd_chk("R7 read-only reg ignores set/clr", 8'h20, 32'hA5A5_0000);
    endtask

    task automatic t_aliases();
        wr_ok("R3", 8'h10, 32'h0000_00F0);
        wr_ok("R3", 8'h14, 32'h0F00_000F);
        rd_chk("R3 set alias ORs", 8'h10, 32'h0F00_00FF);
        wr_ok("R4", 8'h18, 32'h0000_00F0);
        rd_chk("R4 clear alias", 8'h10, 32'h0F00_000F);
        wr_ok("R5", 8'h1C, 32'hFFFF_0000);
        rd_chk("R5 toggle alias", 8'h10, 32'hF0FF_000F);
    endtask

    task automatic t_alias_read();
        rd_chk("R6 set word reads base", 8'h14, 32'hF0FF_000F);
        rd_chk("R6 clear word reads base", 8'h18, 32'hF0FF_000F);
        rd_chk("R6 toggle word reads base", 8'h1C, 32'hF0FF_000F);
        rd_chk("R6 reg3 toggle word reads base", 8'h3C, 32'h8000_3001);
    endtask

    task automatic t_lock();
        wr_ok("R8", 8'h08, 32'hFFFF_FFFF);
        rd_chk("R8 clear alias keeps lock", 8'h00, 32'h8000_0000);
        wr_ok("R8", 8'h3C, 32'hFFFF_FFFF);
        rd_chk("R8 R5 toggle keeps lock", 8'h30, 32'h80FF_CFFE);
        wr_ok("R8", 8'h38, 32'hFFFF_FFFF);
        rd_chk("R8 R4 clear keeps lock", 8'h30, 32'h8000_0000);
    endtask

    task automatic t_bad_access();
        logic [31:0] rd;
        logic er;
        bus(1'b1, 8'h10, 2'd0, 32'hFFFF_FFFF, rd, er);
        check("R9 byte write error", 32'(er), 32'd1);
        check("R9 byte write zero data", rd, 32'd0);
        bus(1'b1, 8'h11, 2'd2, 32'h1234_5678, rd, er);
        check("R9 misaligned write error", 32'(er), 32'd1);
        bus(1'b0, 8'h12, 2'd2, '0, rd, er);
        check("R9 misaligned read error", 32'(er), 32'd1);
        check("R9 misaligned read zero data", rd, 32'd0);
        bus(1'b0, 8'h10, 2'd3, '0, rd, er);
        check("R9 reserved size read error", 32'(er), 32'd1);
        check("R9 reserved size read zero data", rd, 32'd0);
        rd_chk("R9 reg1 unchanged", 8'h10, 32'hF0FF_000F);
    endtask

    task automatic t_out_of_range();
        logic [31:0] rd;
        logic er;
        bus(1'b0, 8'h40, 2'd2, '0, rd, er);
        check("R10 range read error", 32'(er), 32'd1);
        check("R10 range read zero data", rd, 32'd0);
        bus(1'b1, 8'h80, 2'd2, 32'hFFFF_FFFF, rd, er);
        check("R10 range write error", 32'(er), 32'd1);
        rd_chk("R10 reg0 unchanged", 8'h00, 32'h8000_0000);
        rd_chk("R10 reg1 unchanged", 8'h10, 32'hF0FF_000F);
        rd_chk("R10 reg3 unchanged", 8'h30, 32'h8000_0000);
    endtask

    task automatic t_handshake();
        logic [31:0] rd;
        logic er;
        @(negedge clk);
        check("R11 ready high", 32'(req_ready), 32'd1);
        check("R11 no response when idle", 32'(resp_valid), 32'd0);
        bus(1'b0, 8'h00, 2'd2, '0, rd, er);
        @(negedge clk);
        check("R11 response lasts one cycle", 32'(resp_valid), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        check("R11 ready low in reset", 32'(req_ready), 32'd0);
        check("R11 no response in reset", 32'(resp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_readonly();
        t_aliases();
        t_alias_read();
        t_lock();
        t_bad_access();
        t_out_of_range();
        t_handshake();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule